// File: doc/BRIEF.md
# Shared External Bus Ownership and Host Handoff Controller

This block sits in each processor node that shares one external bus with at most one other node and with one asynchronous host. It follows the bus-request lines of all nodes to work out which node is the current owner. It raises its own request line when the local core wants the bus. When the owner gives the bus up, it hands the bus over on a transfer boundary. When the host asks for the bus, the owning node parks it for the host and raises the host grant. Tri-state and open-drain pins appear as value/enable pairs, so the pad ring can build the real drivers.

The host request outranks all node-to-node arbitration. When the host holds the grant, the owner stops driving the address, data, select and strobe groups, but it keeps driving the SDRAM control group. The host ready line is driven only while the host is both selecting the node and requesting the bus. The line can be driven low only (open-drain style), or actively to both levels.

Top module: `busown_ctrl`

## Requirements
- R1: The host request, host select, peer request and core-priority inputs each pass through SYNC_STAGES (default 2) flip-flops before any logic uses them. A change made just after a clock edge cannot affect rdy_oe until SYNC_STAGES edges have passed.
- R2: With node_id = 2'b00 (single node), the node owns the bus from reset: bus_oe = 1 and sdram_oe = 1. It never enables any request line (req_oe = 0).
- R3: When the owner sees a host request, it keeps the bus until xfer_done pulses. It then raises hgrant_out, drops bus_oe and keeps sdram_oe at 1.
- R4: hgrant_out stays high for as long as the host request stays high. After the request drops, the grant falls and bus_oe returns to 1.
- R5: A node enables only its own request line. node_id 2'b01 uses bit 0 of req_out/req_oe, and node_id 2'b10 uses bit 1. The other line is only watched.
- R6: rdy_oe can be 1 only while the synchronized host select and host request are both 1. With rdy_push = 0 the line is driven low only while mem_wait = 1. With rdy_push = 1 it is always driven, and rdy_out = ~mem_wait.
- R7: The owning node keeps the bus while another line requests, and gives it up only when xfer_done pulses. After that, bus_oe = 0 and its own line is raised again if it still wants the bus.
- R8: When both nodes' requests reach an idle bus in the same cycle, the node on line 1 (bit 0) wins.
- R9: If the core-priority line is high and another node is requesting, the owner gives the bus up on a cycle_end pulse. Without core priority, a cycle_end pulse alone has no effect.
- R10: A host request that is pending when xfer_done pulses wins over a peer request present in the same cycle. The owner keeps its own line high and grants the host.
- R11: A node that does not own the bus never enables or raises the host grant (hgrant_oe = 0, hgrant_out = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| node_id | input | IDW | Node number, static; 0 means single node |
| own_want | input | 1 | Local core wants the external bus |
| xfer_done | input | 1 | Pulse at the end of the owner's transfer |
| cycle_end | input | 1 | Pulse at the end of each single bus cycle |
| host_req_a | input | 1 | Host bus request (asynchronous) |
| host_sel_a | input | 1 | Host selects this node (asynchronous) |
| peer_req_a | input | NODES | Bus-request lines as seen on the board (asynchronous) |
| core_pri_a | input | 1 | Shared core-priority line (asynchronous) |
| mem_wait | input | 1 | Internal memory not yet ready for a host access |
| rdy_push | input | 1 | 1: ready is actively driven; 0: driven low only |
| req_out | output | NODES | Value of the request lines |
| req_oe | output | NODES | Enables for the request lines |
| hgrant_out | output | 1 | Host grant value |
| hgrant_oe | output | 1 | Host grant drive enable (owner only) |
| bus_oe | output | 1 | Enable for the address, data, select and strobe groups |
| sdram_oe | output | 1 | Enable for the SDRAM control group |
| rdy_out | output | 1 | Host ready value |
| rdy_oe | output | 1 | Host ready drive enable |

## Verification
A host request and a peer request can both be present when the owner's xfer_done pulse arrives. The bench provokes this by raising a peer line and the host request together and then pulsing xfer_done once. It passes only if the grant rises, the node's own line stays high and bus_oe falls while sdram_oe holds. A second collision is between a cycle_end pulse under core priority and a cycle_end pulse without it. The bench issues both and judges each by whether the node lets go of the bus.

// File: rtl/busown_pkg.sv
package busown_pkg;
   typedef enum logic [1:0] {
      HS_IDLE  = 2'd0,
      HS_WAIT  = 2'd1,
      HS_GRANT = 2'd2
   } host_st_e;
endpackage

// File: rtl/busown_sync.sv
module busown_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad
      $error("busown_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/busown_track.sv
module busown_track #(
   parameter int NODES = 2,
   parameter int IDW   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NODES-1:0] lines,
   output logic [IDW-1:0]   cur_mst
);
   logic [IDW-1:0] lowest;
   logic           owner_live;

   always_comb begin
      lowest = '0;
      for (int i = NODES-1; i >= 0; i--) begin
         if (lines[i]) lowest = IDW'(i+1);
      end
   end

   always_comb begin
      owner_live = 1'b0;
      for (int i = 0; i < NODES; i++) begin
         if (cur_mst == IDW'(i+1) && lines[i]) owner_live = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_mst <= '0;
      else if (!owner_live) cur_mst <= lowest;
   end

   AST_OWNER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mst != '0) && owner_live |=> cur_mst == $past(cur_mst)); // R7
endmodule

// File: rtl/busown_host.sv
module busown_host
   import busown_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hreq_s,
   input  logic is_master,
   input  logic xfer_done,
   output logic busy,
   output logic grant
);
   host_st_e st, st_d;

   always_comb begin
      st_d = st;
      case (st)
         HS_IDLE:  if (hreq_s && is_master) st_d = HS_WAIT;
         HS_WAIT: begin
            if (!hreq_s || !is_master) st_d = HS_IDLE;
            else if (xfer_done)        st_d = HS_GRANT;
         end
         HS_GRANT: if (!hreq_s) st_d = HS_IDLE;
         default:  st_d = HS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= HS_IDLE;
      else st <= st_d;
   end

   assign busy  = (st != HS_IDLE);
   assign grant = (st == HS_GRANT);

   AST_GRANT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant) |-> $past(xfer_done)); // R3
   AST_GRANT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      grant && hreq_s |=> grant); // R4
endmodule

// File: rtl/busown_ctrl.sv
module busown_ctrl
   import busown_pkg::*;
#(
   parameter int NODES       = 2,
   parameter int SYNC_STAGES = 2,
   parameter int IDW         = $clog2(NODES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDW-1:0]   node_id,
   input  logic             own_want,
   input  logic             xfer_done,
   input  logic             cycle_end,
   input  logic             host_req_a,
   input  logic             host_sel_a,
   input  logic [NODES-1:0] peer_req_a,
   input  logic             core_pri_a,
   input  logic             mem_wait,
   input  logic             rdy_push,
   output logic [NODES-1:0] req_out,
   output logic [NODES-1:0] req_oe,
   output logic             hgrant_out,
   output logic             hgrant_oe,
   output logic             bus_oe,
   output logic             sdram_oe,
   output logic             rdy_out,
   output logic             rdy_oe
);
   localparam int SW = NODES + 3;

   if (NODES < 1) begin : g_bad_nodes
      $error("busown_ctrl: NODES must be at least 1");
   end
   if (IDW < $clog2(NODES + 1)) begin : g_bad_idw
      $error("busown_ctrl: IDW too narrow for NODES");
   end

   logic [SW-1:0]    async_in, sync_out;
   logic             hreq_s, sel_s, cpa_s;
   logic [NODES-1:0] lines_s, own_mask, lines_eff;
   logic [IDW-1:0]   cur_mst;
   logic             single, br_q, br_d, is_master, other_req, yield_now;
   logic             host_busy, grant;

   assign async_in = {core_pri_a, host_sel_a, host_req_a, peer_req_a};

   busown_sync #(.STAGES(SYNC_STAGES), .W(SW)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(async_in), .q(sync_out)
   );

   assign lines_s = sync_out[NODES-1:0];
   assign hreq_s  = sync_out[NODES];
   assign sel_s   = sync_out[NODES+1];
   assign cpa_s   = sync_out[NODES+2];

   for (genvar i = 0; i < NODES; i++) begin : g_mask
      assign own_mask[i] = (node_id == IDW'(i+1));
   end

   assign single    = (node_id == '0);
   assign lines_eff = (lines_s & ~own_mask) | (own_mask & {NODES{br_q}});
   assign other_req = |(lines_s & ~own_mask);

   busown_track #(.NODES(NODES), .IDW(IDW)) u_track (
      .clk(clk), .rst_n(rst_n), .lines(lines_eff), .cur_mst(cur_mst)
   );

   assign is_master = single | ((cur_mst == node_id) & br_q);

   assign yield_now = ~host_busy &
                      ((xfer_done & (other_req | ~own_want)) |
                       (cycle_end & cpa_s & other_req));

   always_comb begin
      if (single)         br_d = 1'b0;
      else if (is_master) br_d = ~yield_now;
      else                br_d = own_want;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) br_q <= 1'b0;
      else br_q <= br_d;
   end

   busown_host u_host (
      .clk(clk), .rst_n(rst_n), .hreq_s(hreq_s), .is_master(is_master),
      .xfer_done(xfer_done), .busy(host_busy), .grant(grant)
   );

   assign req_out    = own_mask & {NODES{br_q}};
   assign req_oe     = own_mask;
   assign hgrant_out = grant;
   assign hgrant_oe  = is_master;
   assign bus_oe     = is_master & ~grant;
   assign sdram_oe   = is_master;
   assign rdy_oe     = sel_s & hreq_s & (rdy_push | mem_wait);
   assign rdy_out    = rdy_push & ~mem_wait;

   AST_MASTER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      is_master && !xfer_done && !cycle_end |=> is_master); // R7
   AST_FLOAT_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      hgrant_out |-> !bus_oe && sdram_oe); // R3
   AST_RDY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_oe |-> sel_s && hreq_s); // R6
   AST_GRANT_BY_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      hgrant_out |-> hgrant_oe); // R11
endmodule

// File: tb/test_busown_ctrl.sv
module test_busown_ctrl;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] node_id;
   logic       own_want, xfer_done, cycle_end, host_req_a, host_sel_a;
   logic [1:0] peer_req_a;
   logic       core_pri_a, mem_wait, rdy_push;
   logic [1:0] req_out, req_oe;
   logic       hgrant_out, hgrant_oe, bus_oe, sdram_oe, rdy_out, rdy_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   busown_ctrl i_busown_ctrl (
      .clk(clk), .rst_n(rst_n), .node_id(node_id), .own_want(own_want),
      .xfer_done(xfer_done), .cycle_end(cycle_end), .host_req_a(host_req_a),
      .host_sel_a(host_sel_a), .peer_req_a(peer_req_a), .core_pri_a(core_pri_a),
      .mem_wait(mem_wait), .rdy_push(rdy_push), .req_out(req_out),
      .req_oe(req_oe), .hgrant_out(hgrant_out), .hgrant_oe(hgrant_oe),
      .bus_oe(bus_oe), .sdram_oe(sdram_oe), .rdy_out(rdy_out), .rdy_oe(rdy_oe)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic start(input logic [1:0] id);
      rst_n = 1'b0; node_id = id; own_want = 0; xfer_done = 0; cycle_end = 0;
      host_req_a = 0; host_sel_a = 0; peer_req_a = 0; core_pri_a = 0;
      mem_wait = 0; rdy_push = 0;
      tick(2);
      rst_n = 1'b1;
      tick(1);
   endtask

   task automatic pulse_done();
      xfer_done = 1'b1; tick(1); xfer_done = 1'b0;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R2: single node owns the bus from reset
      start(2'b00);
      chk("R2 reset ownership", {bus_oe, sdram_oe, hgrant_out, 1'b0}, 4'b1100);
      chk("R2 no request line", {2'b00, req_oe}, 4'b0000);

      // R1: synchronizer latency on the ready path
      mem_wait = 1; rdy_push = 1; host_sel_a = 1; host_req_a = 1;
      tick(1);
      chk("R1 after one edge", {3'b000, rdy_oe}, 4'b0000);
      tick(1);
      chk("R1 after two edges", {3'b000, rdy_oe}, 4'b0001);
      host_req_a = 0; host_sel_a = 0; tick(4);

      // R6: sweep select, request, wait, drive mode
      for (int v = 0; v < 16; v++) begin
         logic e_oe, e_out;
         host_sel_a = v[0]; host_req_a = v[1]; mem_wait = v[2]; rdy_push = v[3];
         tick(4);
         e_oe  = v[0] & v[1] & (v[3] | v[2]);
         e_out = v[3] & ~v[2];
         chk($sformatf("R6 ready combo %0d", v), {2'b00, rdy_oe, rdy_oe & rdy_out},
             {2'b00, e_oe, e_oe & e_out});
      end
      host_sel_a = 0; host_req_a = 0; tick(4);

      // R3/R4 in single-node mode
      host_req_a = 1; tick(6);
      chk("R3 waits for done", {bus_oe, hgrant_out, 2'b00}, 4'b1000);
      pulse_done(); tick(1);
      chk("R3 grant floats bus", {bus_oe, sdram_oe, hgrant_out, hgrant_oe}, 4'b0111);
      tick(10);
      chk("R4 grant held", {3'b000, hgrant_out}, 4'b0001);
      host_req_a = 0; tick(6);
      chk("R4 grant released", {bus_oe, hgrant_out, 2'b00}, 4'b1000);

      // R5/R7: node on line 1 takes and holds the bus
      start(2'b01);
      own_want = 1; tick(6);
      chk("R5 own line only", {req_oe, req_out}, 4'b0101);
      chk("R7 owns idle bus", {3'b000, bus_oe}, 4'b0001);
      peer_req_a = 2'b10; tick(8);
      chk("R7 holds while peer waits", {3'b000, bus_oe}, 4'b0001);
      // R9: cycle_end alone has no effect
      cycle_end = 1; tick(1); cycle_end = 0; tick(4);
      chk("R9 cycle end without priority", {3'b000, bus_oe}, 4'b0001);
      pulse_done(); tick(4);
      chk("R7 yields at done", {1'b0, bus_oe, req_out}, 4'b0001);
      peer_req_a = 2'b00; tick(6);
      chk("R7 regains after peer drop", {3'b000, bus_oe}, 4'b0001);

      // R9: core priority lets the peer take at a cycle end
      core_pri_a = 1; peer_req_a = 2'b10; tick(4);
      cycle_end = 1; tick(1); cycle_end = 0; tick(3);
      chk("R9 priority yield", {3'b000, bus_oe}, 4'b0000);
      core_pri_a = 0; peer_req_a = 2'b00; tick(6);

      // R10: host and peer collide at the same done pulse
      peer_req_a = 2'b10; host_req_a = 1; tick(6);
      pulse_done(); tick(1);
      chk("R10 host beats peer", {hgrant_out, bus_oe, sdram_oe, req_out[0]}, 4'b1011);
      host_req_a = 0; tick(6);
      chk("R10 owner resumes", {hgrant_out, bus_oe, 2'b00}, 4'b0100);
      peer_req_a = 2'b00; tick(4);

      // R8/R5: node on line 2 loses a simultaneous request
      start(2'b10);
      peer_req_a = 2'b01; tick(1);
      own_want = 1; tick(8);
      chk("R8 lower line wins", {1'b0, bus_oe, req_out}, 4'b0010);
      chk("R5 line two enable", {2'b00, req_oe}, 4'b0010);

      // R11: non-owner ignores the host
      host_req_a = 1; tick(6);
      pulse_done(); tick(4);
      chk("R11 no grant from non-owner", {2'b00, hgrant_out, hgrant_oe}, 4'b0000);
      host_req_a = 0; peer_req_a = 2'b00; tick(6);
      chk("R8 takes after peer leaves", {3'b000, bus_oe}, 4'b0001);

      // R8: node on line 1 wins a simultaneous request
      start(2'b01);
      peer_req_a = 2'b10; tick(1);
      own_want = 1; tick(8);
      chk("R8 line one wins", {3'b000, bus_oe}, 4'b0001);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule